// File: doc/BRIEF.md
# Multiplexed Byte-Bus Memory Slave

This block sits on the memory side of a microcontroller bus that has only eight lines. The same lines carry the address and the data. A 16-bit address therefore arrives in two byte-wide phases, and each phase is marked by its own pulse on an address-latch input. Once both halves are held, the master raises a read strobe to fetch one byte or a write strobe to deposit one. The slave captures both address halves and decodes the full 64K space, which program and data share. It answers only inside its own window. It drives the shared lines only while it returns read data.

The storage is a small register array that covers a parameterized window of `WIN_BYTES` bytes, starting at `BASE_ADDR`. The lowest 256 addresses belong to the processor's internal register file, so the slave never answers them, even where the window overlaps them. A memory-off input takes the slave off the bus, so that an external board can serve the same addresses. If a strobe arrives after only one address phase, the transfer is dropped and a one-cycle error pulse is raised. All inputs are sampled on the rising clock edge. The edges of the latch and strobe inputs are detected synchronously.

Top module: `mbus_mem_slave`

## Requirements
- R1: After synchronous reset, `bus_oe_o` and `proto_err_o` are low and no address is held. A strobe issued before any latch pulse is ignored (no drive, no error).
- R2: The first latch pulse after idle captures `bus_i` as address bits 7:0. The second captures bits 15:8 and completes the address. A third pulse before any strobe starts a new address as its low byte.
- R3: While `rd_i` is high with a complete address that is claimed and `mem_off_i` low, `bus_oe_o` is high in the same cycle and `bus_o` carries the stored byte. Otherwise `bus_oe_o` is low and `bus_o` is 0.
- R4: On the first cycle `wr_i` is sampled high with a complete claimed address and `mem_off_i` low, the byte on `bus_i` is stored at that address.
- R5: Addresses 0x0000 to 0x00FF are never answered or written, even when they fall inside the window.
- R6: Addresses outside `BASE_ADDR` to `BASE_ADDR + WIN_BYTES - 1` are never answered or written.
- R7: While `mem_off_i` is high, the slave does not drive the bus and writes leave the stored byte unchanged.
- R8: A strobe whose rising edge finds only one address byte held is ignored. `proto_err_o` is high for exactly the cycle after that edge is sampled.
- R9: When a read or write strobe falls, the held address is discarded. A later strobe without new latch pulses is ignored and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ale_i | input | 1 | Address-latch pulse, one per address byte |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| mem_off_i | input | 1 | Takes the slave off the bus when high |
| bus_i | input | 8 | Value sensed on the shared address/data lines |
| bus_o | output | 8 | Read data to drive on the shared lines |
| bus_oe_o | output | 1 | Drive enable for the shared lines |
| proto_err_o | output | 1 | One-cycle pulse: strobe after a half address |

## Verification
A wrong phase state shows up on the very next strobe. If the slave falls one phase behind, either the read enable stays low when it should rise, or the data comes from an address built from the wrong bytes. A dropped error pulse, or one that is misplaced, is visible in the single cycle after the strobe edge. A decode fault, whether in the low-page exclusion or at the window edges, shows as a drive enable in the same cycle as the read strobe. A write fault with the slave disabled, or one that spills into a neighbouring byte, stays hidden until a later read back of that location, so the sweeps read every location that was written.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_FULL = 2'd2
    } phase_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } addr_s;

    typedef struct packed {
        logic rise_ale;
        logic rise_rd;
        logic rise_wr;
        logic fall_rd;
        logic fall_wr;
    } edges_s;

    localparam logic [16:0] REG_FILE_END = 17'h00100;

    function automatic logic claims(input logic [15:0] a,
                                    input logic [16:0] base,
                                    input logic [16:0] span);
        logic [16:0] a17;
        a17 = {1'b0, a};
        return (a17 >= REG_FILE_END) && (a17 >= base) && (a17 < base + span);
    endfunction

endpackage

// File: rtl/mbs_edges.sv
module mbs_edges
    import mbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ale_i,
    input  logic   rd_i,
    input  logic   wr_i,
    output edges_s ev_o
);
    logic ale_q, rd_q, wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q <= 1'b0;
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            ale_q <= ale_i;
            rd_q  <= rd_i;
            wr_q  <= wr_i;
        end
    end

    always_comb begin
        ev_o.rise_ale = ale_i & ~ale_q;
        ev_o.rise_rd  = rd_i & ~rd_q;
        ev_o.rise_wr  = wr_i & ~wr_q;
        ev_o.fall_rd  = ~rd_i & rd_q;
        ev_o.fall_wr  = ~wr_i & wr_q;
    end

endmodule

// File: rtl/mbs_addr_track.sv
module mbs_addr_track
    import mbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edges_s     ev_i,
    input  logic [7:0] bus_i,
    output phase_e     phase_o,
    output addr_s      addr_o,
    output logic       err_o
);
    phase_e phase_q;
    addr_s  addr_q;
    logic   err_q;
    logic   strobe_end;

    assign strobe_end = ev_i.fall_rd | ev_i.fall_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            addr_q  <= '0;
        end else if (strobe_end) begin
            phase_q <= PH_IDLE;
        end else if (ev_i.rise_ale) begin
            if (phase_q == PH_LOW) begin
                addr_q.hi <= bus_i;
                phase_q   <= PH_FULL;
            end else begin
                addr_q.lo <= bus_i;
                phase_q   <= PH_LOW;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= (ev_i.rise_rd | ev_i.rise_wr) && (phase_q == PH_LOW);
    end

    assign phase_o = phase_q;
    assign addr_o  = addr_q;
    assign err_o   = err_q;

    // R2: a latch pulse on a half address completes it
    p_half_then_full_r2: assert property (@(posedge clk) disable iff (rst)
        (ev_i.rise_ale && !strobe_end && phase_q == PH_LOW) |=> (phase_q == PH_FULL));

    // R9: the end of a strobe discards the held address
    p_strobe_end_idle_r9: assert property (@(posedge clk) disable iff (rst)
        strobe_end |=> (phase_q == PH_IDLE));

    // R8: an error pulse follows only a half address
    p_err_after_half_r8: assert property (@(posedge clk) disable iff (rst)
        err_q |-> ($past(phase_q) == PH_LOW));

endmodule

// File: rtl/mbs_window.sv
module mbs_window
    import mbs_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h1000,
    parameter int unsigned WIN_BYTES = 1024,
    localparam int unsigned IDX_W    = $clog2(WIN_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  addr_s            addr_i,
    input  phase_e           phase_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [16:0] BASE17 = {1'b0, BASE_ADDR};
    localparam logic [16:0] SPAN17 = 17'(WIN_BYTES);

    assign hit_o = (phase_i == PH_FULL) && claims(addr_i, BASE17, SPAN17);
    assign idx_o = IDX_W'(addr_i - BASE_ADDR);

    // R6: a hit lies inside the window and above the register file (R5)
    p_hit_in_window_r6: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (({1'b0, addr_i} - BASE17) < SPAN17) && (addr_i.hi != 8'h00));

endmodule

// File: rtl/mbs_store.sv
module mbs_store #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) cells[idx_i] <= wdata_i;
    end

    assign rdata_o = cells[idx_i];

endmodule

// File: rtl/mbus_mem_slave.sv
module mbus_mem_slave
    import mbs_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h1000,
    parameter int unsigned WIN_BYTES = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ale_i,
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic       mem_off_i,
    input  logic [7:0] bus_i,
    output logic [7:0] bus_o,
    output logic       bus_oe_o,
    output logic       proto_err_o
);
    localparam int unsigned IDX_W = $clog2(WIN_BYTES);

    edges_s           ev;
    phase_e           phase;
    addr_s            addr;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             we;
    logic [7:0]       rdata;

    mbs_edges u_edges (
        .clk(clk), .rst(rst), .ale_i(ale_i), .rd_i(rd_i), .wr_i(wr_i), .ev_o(ev)
    );

    mbs_addr_track u_track (
        .clk(clk), .rst(rst), .ev_i(ev), .bus_i(bus_i),
        .phase_o(phase), .addr_o(addr), .err_o(proto_err_o)
    );

    mbs_window #(.BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)) u_window (
        .clk(clk), .rst(rst), .addr_i(addr), .phase_i(phase),
        .hit_o(hit), .idx_o(idx)
    );

    assign we = ev.rise_wr & hit & ~mem_off_i;

    mbs_store #(.DEPTH(WIN_BYTES)) u_store (
        .clk(clk), .we_i(we), .idx_i(idx), .wdata_i(bus_i), .rdata_o(rdata)
    );

    assign bus_oe_o = rd_i & hit & ~mem_off_i;
    assign bus_o    = bus_oe_o ? rdata : 8'h00;

    // R3: the slave drives only during a read on a complete address
    p_drive_needs_addr_r3: assert property (@(posedge clk) disable iff (rst)
        bus_oe_o |-> (phase == PH_FULL) && rd_i);

    // R7: no drive and no store while taken off the bus
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        mem_off_i |-> !bus_oe_o && !we);

    // R5: the register-file page is never touched
    p_low_page_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_oe_o || we) |-> (addr.hi != 8'h00));

    // R4: a store happens only with a complete address
    p_write_full_r4: assert property (@(posedge clk) disable iff (rst)
        we |-> (phase == PH_FULL) && !$past(wr_i));

endmodule

// File: tb/mbus_mem_slave_bench.sv
module mbus_mem_slave_bench;

    localparam logic [15:0] BASE = 16'h0080;
    localparam int unsigned WIN  = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ale = 1'b0, rd = 1'b0, wr = 1'b0, off = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic oe, perr;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    mbus_mem_slave #(.BASE_ADDR(BASE), .WIN_BYTES(WIN)) u_mbus_mem_slave (
        .clk(clk), .rst(rst), .ale_i(ale), .rd_i(rd), .wr_i(wr),
        .mem_off_i(off), .bus_i(bus_in), .bus_o(bus_out),
        .bus_oe_o(oe), .proto_err_o(perr)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ (a[15:8] * 8'd37) ^ 8'hA5;
    endfunction

    function automatic logic served(input logic [15:0] a);
        return (a >= 16'h0100) && (a >= BASE) && ({1'b0, a} < {1'b0, BASE} + 17'(WIN));
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic latch_byte(input logic [7:0] b);
        @(negedge clk); bus_in = b; ale = 1'b1;
        @(negedge clk); ale = 1'b0;
    endtask

    task automatic strobe_rd(input logic o, output logic e_oe, output logic [7:0] d, output logic e);
        @(negedge clk); off = o; rd = 1'b1;
        #2; e_oe = oe; d = bus_out;
        @(negedge clk); #2; e = perr; rd = 1'b0;
        @(negedge clk); @(negedge clk); off = 1'b0;
    endtask

    task automatic strobe_wr(input logic [7:0] d, input logic o, output logic e);
        @(negedge clk); off = o; bus_in = d; wr = 1'b1;
        @(negedge clk); #2; e = perr; wr = 1'b0;
        @(negedge clk); @(negedge clk); off = 1'b0;
    endtask

    task automatic wr_at(input logic [15:0] a, input logic [7:0] d, input logic o);
        logic e;
        latch_byte(a[7:0]); latch_byte(a[15:8]);
        strobe_wr(d, o, e);
    endtask

    task automatic rd_at(input logic [15:0] a, input logic o,
                         output logic e_oe, output logic [7:0] d, output logic e);
        latch_byte(a[7:0]); latch_byte(a[15:8]);
        strobe_rd(o, e_oe, d, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic g_oe, g_e;
        logic [7:0] g_d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 reset oe", 16'(oe), 16'h0);
        check("R1 reset err", 16'(perr), 16'h0);
        strobe_rd(1'b0, g_oe, g_d, g_e);
        check("R1 strobe without latch oe", 16'(g_oe), 16'h0);
        check("R1 strobe without latch err", 16'(g_e), 16'h0);

        // R4 sweep of writes over every served address
        for (int a = 16'h0100; a < 16'h0280; a++) wr_at(16'(a), pat(16'(a)), 1'b0);
        // R3 / R2 read back every served address
        for (int a = 16'h0100; a < 16'h0280; a++) begin
            rd_at(16'(a), 1'b0, g_oe, g_d, g_e);
            check("R3 read oe", 16'(g_oe), 16'h1);
            check("R4 read data", 16'(g_d), 16'(pat(16'(a))));
            check("R3 read err", 16'(g_e), 16'h0);
        end
        // R5 register-file page never answered
        for (int a = 0; a < 16'h0100; a++) begin
            rd_at(16'(a), 1'b0, g_oe, g_d, g_e);
            check("R5 low page oe", 16'(g_oe), 16'(served(16'(a))));
            check("R5 low page data", 16'(g_d), 16'h0);
        end
        // R6 above the window
        for (int a = 16'h0280; a < 16'h0300; a++) begin
            rd_at(16'(a), 1'b0, g_oe, g_d, g_e);
            check("R6 above window oe", 16'(g_oe), 16'(served(16'(a))));
        end
        rd_at(16'hFFFF, 1'b0, g_oe, g_d, g_e);
        check("R6 top address oe", 16'(g_oe), 16'h0);
        rd_at(16'h0480, 1'b0, g_oe, g_d, g_e);
        check("R6 aliased address oe", 16'(g_oe), 16'h0);
        // R6 write outside must not alias into the window
        wr_at(16'h0300, 8'h3C, 1'b0);
        rd_at(16'h0100, 1'b0, g_oe, g_d, g_e);
        check("R6 no alias write", 16'(g_d), 16'(pat(16'h0100)));

        // R7 taken off the bus
        rd_at(16'h0123, 1'b1, g_oe, g_d, g_e);
        check("R7 off no drive", 16'(g_oe), 16'h0);
        wr_at(16'h0123, 8'h5A, 1'b1);
        rd_at(16'h0123, 1'b0, g_oe, g_d, g_e);
        check("R7 off write ignored", 16'(g_d), 16'(pat(16'h0123)));

        // R8 strobe after a half address
        latch_byte(8'h50);
        strobe_rd(1'b0, g_oe, g_d, g_e);
        check("R8 half read oe", 16'(g_oe), 16'h0);
        check("R8 half read err", 16'(g_e), 16'h1);
        #0;
        check("R8 err one cycle", 16'(perr), 16'h0);
        latch_byte(8'h50);
        strobe_wr(8'hEE, 1'b0, g_e);
        check("R8 half write err", 16'(g_e), 16'h1);
        rd_at(16'h0150, 1'b0, g_oe, g_d, g_e);
        check("R8 half write ignored", 16'(g_d), 16'(pat(16'h0150)));
        check("R8 full read no err", 16'(g_e), 16'h0);

        // R9 strobe end discards the address
        rd_at(16'h0140, 1'b0, g_oe, g_d, g_e);
        check("R9 first read oe", 16'(g_oe), 16'h1);
        strobe_rd(1'b0, g_oe, g_d, g_e);
        check("R9 repeat read oe", 16'(g_oe), 16'h0);
        check("R9 repeat read err", 16'(g_e), 16'h0);

        // R2 a third pulse starts a new address
        latch_byte(8'h11); latch_byte(8'h01);
        latch_byte(8'h60); latch_byte(8'h02);
        strobe_rd(1'b0, g_oe, g_d, g_e);
        check("R2 restart oe", 16'(g_oe), 16'h1);
        check("R2 restart data", 16'(g_d), 16'(pat(16'h0260)));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule